// File: doc/BRIEF.md
# Multiplexed Parallel Port Sequencer

This block turns single 32-bit word transfer requests into bus activity on a narrow external bus that carries both address and data on the same wires. It runs on a clock at twice the processor core rate and has no bus clock of its own, so every bus timing is a whole number of core cycles, and each core cycle is two ticks of the block clock. A word moves as a train of narrow data phases: four byte phases on an 8-bit memory or two halfword phases on a 16-bit memory. The least significant slice always goes first.

Before the data phases the block may issue one address latch phase. This phase puts the upper address bits (the page) on the shared bus and pulses the latch enable, so that an external latch can hold them. The latch phase is skipped when the access moves sequentially (modifier of +1) inside the page that was latched last. The data phase length is programmable, and an optional hold cycle at the end of each data phase keeps the bus value after the strobe has gone low. A request is taken with a one-tick acknowledge. For reads, the assembled word is presented with a completion pulse.

Top module: `ppSeq`

## Requirements
- R1: While no transfer is in progress, busAle, busOe, busRd and busWr are low and busAd is zero. This is also the state after reset.
- R2: A latch phase lasts 6 ticks (3 core cycles) for any duration or hold setting. busOe is high and busAd carries the page reqAddr[23:8] on all 6 ticks. busAle is high on ticks 2 to 5 only, which gives one tick of address setup and one tick of hold.
- R3: With cfgDur in 3..32, each data phase asserts its strobe for 2*cfgDur ticks. A phase without a hold cycle is followed at once by the next phase.
- R4: A cfgDur value below 3 acts as 3, and a value above 32 acts as 32.
- R5: When cfgHold is 1, each data phase is followed by 2 ticks with both strobes low. During these ticks busAd and busOe keep their last data-phase values.
- R6: With reqWide=0 (8-bit), a word takes 4 data phases. Byte 0 is sent first, on busAd[7:0], with busAd[15:8] zero.
- R7: With reqWide=1 (16-bit), a word takes 2 data phases, with the low halfword first on busAd[15:0].
- R8: On a read (reqWrite=0), busRd replaces busWr and busOe stays low during the data phases. busIn is sampled on the last strobe tick of each phase and assembled least significant slice first. rdData holds the word during the one-tick xferDone pulse that follows the last phase.
- R9: A latch phase precedes the data phases on the first transfer after reset, and whenever reqMod is not 1. Otherwise it precedes them only when the page differs from the page last latched.
- R10: reqAck is high in the same tick as reqValid whenever the block is idle. While a transfer runs, reqAck stays low, and request inputs have no effect on the bus.
- R11: A write transfer also ends with a single-tick xferDone pulse one tick after its last phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the core rate |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Transfer request |
| reqAck | output | 1 | Request taken this tick |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWide | input | 1 | 1 = 16-bit memory, 0 = 8-bit |
| reqAddr | input | 24 | Word address; bits 23:8 form the page |
| reqMod | input | 8 | Address modifier; 1 means sequential |
| reqData | input | 32 | Write word |
| cfgDur | input | 6 | Data phase length in core cycles |
| cfgHold | input | 1 | Adds a hold cycle to each data phase |
| busAd | output | 16 | Shared address/data bus output |
| busIn | input | 16 | Bus read data |
| busOe | output | 1 | Bus output enable |
| busAle | output | 1 | Address latch enable |
| busRd | output | 1 | Read strobe |
| busWr | output | 1 | Write strobe |
| rdData | output | 32 | Assembled read word |
| xferDone | output | 1 | Transfer complete pulse |

## Verification
A corrupted tick counter or phase index shows at once on the pins. A strobe edge, a latch enable edge or the completion pulse lands one or more ticks away from where the duration setting puts it. A stale page register shows as a latch phase that is missing or one too many, on the first tick of the next transfer. A wrong slice order or a wrong sampling tick shows on busAd during the same data phase, or in rdData at the completion pulse. Because of this, the bench compares every pin on every tick against an independently built expected trace.

// File: rtl/ppSeqPkg.sv
package ppSeqPkg;
  localparam int LATCH_TICKS = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LATCH,
    ST_DATA,
    ST_HOLD
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture request, page and word
    logic drvPage;  // latch phase: page on bus
    logic drvData;  // data or hold phase
    logic sample;   // last strobe tick: bus input valid
    logic advance;  // end of a data phase: shift word
    logic hold;     // hold tick
  } seqCtl_t;
endpackage

// File: rtl/ppSeqCtrl.sv
module ppSeqCtrl
  import ppSeqPkg::*;
#(
  parameter int DUR_W   = 6,
  parameter int DUR_MIN = 3,
  parameter int DUR_MAX = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqWide,
  input  logic [DUR_W-1:0] cfgDur,
  input  logic             cfgHold,
  input  logic             pageMiss,
  output logic             reqAck,
  output seqCtl_t          ctl,
  output logic             busAle,
  output logic             busRd,
  output logic             busWr,
  output logic             xferDone
);
  localparam int CNT_W = DUR_W + 1;
  localparam logic [CNT_W-1:0] LATCH_LAST = CNT_W'(LATCH_TICKS - 1);

  seqState_t        stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] strobeLastQ;
  logic [1:0]       phaseQ;
  logic             holdQ, wideQ, writeQ, doneQ;
  logic [DUR_W-1:0] durSat;
  logic             lastPhase, strobeEnd, holdEnd;

  always_comb begin
    if (cfgDur < DUR_W'(DUR_MIN))      durSat = DUR_W'(DUR_MIN);
    else if (cfgDur > DUR_W'(DUR_MAX)) durSat = DUR_W'(DUR_MAX);
    else                               durSat = cfgDur;
  end

  assign lastPhase = (phaseQ == (wideQ ? 2'd1 : 2'd3));
  assign strobeEnd = (stateQ == ST_DATA) && (cntQ == strobeLastQ);
  assign holdEnd   = (stateQ == ST_HOLD) && (cntQ == CNT_W'(1));

  always_comb begin
    ctl         = '0;
    ctl.load    = (stateQ == ST_IDLE) && reqValid;
    ctl.drvPage = (stateQ == ST_LATCH);
    ctl.drvData = (stateQ == ST_DATA) || (stateQ == ST_HOLD);
    ctl.sample  = strobeEnd;
    ctl.advance = (strobeEnd && !holdQ) || holdEnd;
    ctl.hold    = (stateQ == ST_HOLD);
  end

  assign reqAck   = ctl.load;
  assign busAle   = (stateQ == ST_LATCH) && (cntQ != '0) && (cntQ != LATCH_LAST);
  assign busRd    = (stateQ == ST_DATA) && !writeQ;
  assign busWr    = (stateQ == ST_DATA) && writeQ;
  assign xferDone = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      cntQ        <= '0;
      strobeLastQ <= '0;
      phaseQ      <= '0;
      holdQ       <= 1'b0;
      wideQ       <= 1'b0;
      writeQ      <= 1'b0;
      doneQ       <= 1'b0;
    end else begin
      doneQ <= ctl.advance && lastPhase;
      unique case (stateQ)
        ST_IDLE: if (ctl.load) begin
          strobeLastQ <= {durSat, 1'b0} - CNT_W'(1);
          holdQ       <= cfgHold;
          wideQ       <= reqWide;
          writeQ      <= reqWrite;
          phaseQ      <= '0;
          cntQ        <= '0;
          stateQ      <= pageMiss ? ST_LATCH : ST_DATA;
        end
        ST_LATCH: begin
          if (cntQ == LATCH_LAST) begin
            cntQ   <= '0;
            stateQ <= ST_DATA;
          end else cntQ <= cntQ + CNT_W'(1);
        end
        ST_DATA, ST_HOLD: begin
          if (strobeEnd && holdQ) begin
            cntQ   <= '0;
            stateQ <= ST_HOLD;
          end else if (ctl.advance) begin
            cntQ <= '0;
            if (lastPhase) stateQ <= ST_IDLE;
            else begin
              phaseQ <= phaseQ + 2'd1;
              stateQ <= ST_DATA;
            end
          end else cntQ <= cntQ + CNT_W'(1);
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  // R2: latch enable high for exactly 4 ticks
  a_r2_ale_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busAle) |=> busAle ##1 busAle ##1 busAle ##1 !busAle);

  // R3: no strobe run shorter than the minimum of 6 ticks
  a_r3_wr_min_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busWr) |-> ($past(busWr, 6) && $past(busWr, 1)));
  a_r3_rd_min_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRd) |-> ($past(busRd, 6) && $past(busRd, 1)));
endmodule

// File: rtl/ppSeqDatapath.sv
module ppSeqDatapath
  import ppSeqPkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int PAGE_LSB = 8,
  parameter int MOD_W    = 8,
  parameter int BUS_W    = 16,
  parameter int WORD_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MOD_W-1:0]  reqMod,
  input  logic [WORD_W-1:0] reqData,
  input  logic              reqWide,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  busIn,
  output logic              pageMiss,
  output logic [BUS_W-1:0]  busAd,
  output logic              busOe,
  output logic [WORD_W-1:0] rdData
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;
  localparam int BYTE_W = BUS_W / 2;

  logic [PAGE_W-1:0] pageQ, reqPage;
  logic              pageValidQ;
  logic [WORD_W-1:0] wordQ;
  logic [BUS_W-1:0]  sampleQ, inSlice, outSlice;
  logic              wideQ, writeQ;

  assign reqPage  = reqAddr[ADDR_W-1:PAGE_LSB];
  assign pageMiss = !pageValidQ || (reqMod != MOD_W'(1)) || (reqPage != pageQ);
  assign inSlice  = ctl.sample ? busIn : sampleQ;
  assign outSlice = wideQ ? wordQ[BUS_W-1:0] : BUS_W'(wordQ[BYTE_W-1:0]);

  always_comb begin
    if (ctl.drvPage)                busAd = BUS_W'(pageQ);
    else if (ctl.drvData && writeQ) busAd = outSlice;
    else                            busAd = '0;
  end
  assign busOe  = ctl.drvPage || (ctl.drvData && writeQ);
  assign rdData = wordQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ      <= '0;
      pageValidQ <= 1'b0;
      wordQ      <= '0;
      sampleQ    <= '0;
      wideQ      <= 1'b0;
      writeQ     <= 1'b0;
    end else begin
      if (ctl.load) begin
        pageQ      <= reqPage;
        pageValidQ <= 1'b1;
        wordQ      <= reqData;
        wideQ      <= reqWide;
        writeQ     <= reqWrite;
      end
      if (ctl.sample) sampleQ <= busIn;
      if (ctl.advance) begin
        if (wideQ) wordQ <= {inSlice, wordQ[WORD_W-1:BUS_W]};
        else       wordQ <= {inSlice[BYTE_W-1:0], wordQ[WORD_W-1:BYTE_W]};
      end
    end
  end

  // R5: the bus value does not move during a hold tick
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |-> $stable(busAd));
endmodule

// File: rtl/ppSeq.sv
module ppSeq
  import ppSeqPkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int PAGE_LSB = 8,
  parameter int MOD_W    = 8,
  parameter int BUS_W    = 16,
  parameter int WORD_W   = 32,
  parameter int DUR_W    = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqAck,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [MOD_W-1:0]  reqMod,
  input  logic [WORD_W-1:0] reqData,
  input  logic [DUR_W-1:0]  cfgDur,
  input  logic              cfgHold,
  output logic [BUS_W-1:0]  busAd,
  input  logic [BUS_W-1:0]  busIn,
  output logic              busOe,
  output logic              busAle,
  output logic              busRd,
  output logic              busWr,
  output logic [WORD_W-1:0] rdData,
  output logic              xferDone
);
  seqCtl_t ctl;
  logic    pageMiss;

  ppSeqCtrl #(.DUR_W(DUR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWide(reqWide), .cfgDur(cfgDur), .cfgHold(cfgHold),
    .pageMiss(pageMiss), .reqAck(reqAck), .ctl(ctl), .busAle(busAle),
    .busRd(busRd), .busWr(busWr), .xferDone(xferDone)
  );

  ppSeqDatapath #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .MOD_W(MOD_W),
    .BUS_W(BUS_W), .WORD_W(WORD_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqMod(reqMod),
    .reqData(reqData), .reqWide(reqWide), .reqWrite(reqWrite),
    .busIn(busIn), .pageMiss(pageMiss), .busAd(busAd), .busOe(busOe),
    .rdData(rdData)
  );

  // R8: read strobe never coincides with bus drive
  a_r8_read_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> !busOe);
  // R10: a taken request is followed by a busy tick
  a_r10_busy_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);
  // R11: completion is a single-tick pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);
endmodule

// File: tb/ppSeq_tb_top.sv
module ppSeq_tb_top;
  typedef struct {
    logic        ale, oe, rd, wr, done, chk;
    logic [15:0] ad, din;
    logic [31:0] word;
    string       tag;
  } tick_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqWide = 1'b0, cfgHold = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [7:0]  reqMod = 8'd1;
  logic [31:0] reqData = '0;
  logic [5:0]  cfgDur = 6'd3;
  logic [15:0] busIn = '0;
  logic        reqAck, busOe, busAle, busRd, busWr, xferDone;
  logic [15:0] busAd;
  logic [31:0] rdData;

  int checks = 0, errors = 0;
  bit monOn = 0, finished = 0;
  tick_t q[$];
  bit        pageValid = 0;
  logic [15:0] lastPage = '0;

  always #4 clk = ~clk;

  ppSeq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAck(reqAck),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqAddr(reqAddr), .reqMod(reqMod),
    .reqData(reqData), .cfgDur(cfgDur), .cfgHold(cfgHold), .busAd(busAd),
    .busIn(busIn), .busOe(busOe), .busAle(busAle), .busRd(busRd), .busWr(busWr),
    .rdData(rdData), .xferDone(xferDone)
  );

  function automatic tick_t mk(logic ale, logic oe, logic rd, logic wr,
                               logic [15:0] ad, logic [15:0] din, string tag);
    tick_t t;
    t.ale = ale; t.oe = oe; t.rd = rd; t.wr = wr; t.ad = ad; t.din = din;
    t.done = 1'b0; t.chk = 1'b0; t.word = '0; t.tag = tag;
    return t;
  endfunction

  // monitor: one expected item per tick; empty queue means idle (R1)
  always @(negedge clk) begin
    if (monOn) begin
      tick_t e;
      if (q.size() > 0) e = q.pop_front();
      else e = mk(0, 0, 0, 0, '0, '0, "R1");
      busIn <= e.din;
      checks++;
      if (busAle !== e.ale || busOe !== e.oe || busRd !== e.rd ||
          busWr !== e.wr || busAd !== e.ad || xferDone !== e.done) begin
        errors++;
        $display("FAIL %s ale/oe/rd/wr/done=%b%b%b%b%b ad=%h expected %b%b%b%b%b ad=%h",
                 e.tag, busAle, busOe, busRd, busWr, xferDone, busAd,
                 e.ale, e.oe, e.rd, e.wr, e.done, e.ad);
      end
      if (e.chk) begin
        checks++;
        if (rdData !== e.word) begin
          errors++;
          $display("FAIL R8 rdData=%h expected %h", rdData, e.word);
        end
      end
    end
  end

  task automatic doXfer(input bit wr, input bit wide, input logic [23:0] addr,
                        input logic [7:0] mod, input logic [31:0] word,
                        input logic [5:0] dur, input bit hold, input string tag,
                        input int extra);
    int d, nPh, sw;
    bit latch;
    logic [15:0] page;
    tick_t t;
    page  = addr[23:8];
    latch = !pageValid || mod != 8'd1 || page != lastPage;
    pageValid = 1; lastPage = page;
    d   = (dur < 3) ? 3 : (dur > 32) ? 32 : int'(dur);
    nPh = wide ? 2 : 4;
    sw  = wide ? 16 : 8;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqWide = wide; reqAddr = addr; reqMod = mod;
    reqData = wr ? word : ~word; cfgDur = dur; cfgHold = hold;
    #1;
    checks++;
    if (reqAck !== 1'b1) begin
      errors++; $display("FAIL R10 reqAck=%b expected 1", reqAck);
    end
    @(posedge clk);
    if (latch)
      for (int i = 0; i < 6; i++)
        q.push_back(mk(i >= 1 && i <= 4, 1, 0, 0, page, '0, i == 0 ? "R9" : "R2"));
    for (int p = 0; p < nPh; p++) begin
      logic [15:0] sl;
      sl = wide ? word[p*16 +: 16] : {8'h00, word[p*8 +: 8]};
      for (int i = 0; i < 2*d; i++) begin
        t = mk(0, wr, !wr, wr, wr ? sl : 16'h0, sl,
               (!latch && p == 0 && i == 0) ? "R9" : tag);
        q.push_back(t);
      end
      if (hold)
        for (int i = 0; i < 2; i++)
          q.push_back(mk(0, wr, 0, 0, wr ? sl : 16'h0, sl, "R5"));
    end
    t = mk(0, 0, 0, 0, '0, '0, wr ? "R11" : "R8");
    t.done = 1'b1; t.chk = !wr; t.word = word;
    q.push_back(t);
    #1;
    if (extra == 0) reqValid = 0;
    for (int i = 0; i < extra; i++) begin
      @(negedge clk);
      reqData = ~reqData; reqWrite = ~reqWrite; reqAddr = reqAddr ^ 24'hFF0000;
      #1;
      checks++;
      if (reqAck !== 1'b0) begin
        errors++; $display("FAIL R10 reqAck=%b expected 0 while busy", reqAck);
      end
    end
    reqValid = 0;
    if (sw == 0) $display("unreachable");
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    monOn = 1;
    repeat (3) @(negedge clk);
    doXfer(1, 0, 24'h12_3400, 8'd1, 32'hA1B2C3D4, 6'd3, 0, "R6", 0);
    doXfer(1, 0, 24'h12_3401, 8'd1, 32'h0F1E2D3C, 6'd5, 1, "R3", 0);
    doXfer(0, 1, 24'h12_3402, 8'd1, 32'h55AA1234, 6'd4, 1, "R7", 0);
    doXfer(0, 1, 24'h56_7800, 8'd1, 32'hDEADBEEF, 6'd1, 0, "R4", 0);
    doXfer(1, 1, 24'h56_7802, 8'd2, 32'hCAFE8001, 6'd40, 0, "R4", 0);
    doXfer(1, 0, 24'h56_7804, 8'd2, 32'h01020304, 6'd0, 1, "R6", 0);
    doXfer(0, 0, 24'h56_7805, 8'd1, 32'h89ABCDEF, 6'd6, 0, "R10", 4);
    doXfer(1, 1, 24'h56_7806, 8'd1, 32'h76543210, 6'd32, 0, "R3", 0);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired, expected all transfers to finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule